// File: doc/BRIEF.md
# Sliced-Address Accumulator Processor Core

This block is a small 8-bit accumulator processor. Every memory address it produces is 14 bits wide: an 8-bit slice on top and a 6-bit offset below. Instruction fetches use a code-slice register joined to a 6-bit program counter. Operand accesses use either a data-slice register or, when scratch mode is on, a fixed all-zero scratch slice. The core works against one asynchronous byte-wide memory through an address bus, separate write-data and read-data buses, and a read strobe and a write strobe.

An instruction byte carries a 2-bit opcode in bits 7:6 and a 6-bit operand in bits 5:0. The opcodes are 00 NOR, 01 ADD, 10 store and 11 branch-if-carry-clear. Operand values 60 to 63 under the branch opcode are not branch targets. They are four control instructions: 0xFC selects the data slice for operands, 0xFD selects the scratch slice, 0xFE copies the accumulator into the data-slice register, and 0xFF copies it into the code-slice register. After reset the core fetches its first instruction from slice 0x80, offset 0, which is address 0x2000.

A sequencer walks through four named states. CODE_ADDR drives the fetch address. CODE_READ latches the instruction byte. DATA_ADDR drives the operand address. DATA_XFER reads or writes the operand. The transitions are: CODE_ADDR to CODE_READ always; CODE_READ to CODE_ADDR when the fetched opcode is 11, otherwise to DATA_ADDR; DATA_ADDR to DATA_XFER always; DATA_XFER to CODE_ADDR always. Reset enters CODE_ADDR.

Top module: `slice_acc_cpu`

## Requirements
- R1: In the first cycle after reset is released, the core drives address 0x2000 with the read strobe high and the write strobe low.
- R2: Fetch addresses are {code slice, PC}. PC advances by one, modulo 64, with each fetched instruction unless a branch is taken. A branch to its own address therefore holds the fetch address fixed.
- R3: NOR (00aaaaaa) replaces the accumulator with the bitwise NOR of the accumulator and the operand byte, and leaves carry unchanged.
- R4: ADD (01aaaaaa) replaces the accumulator with the low 8 bits of accumulator plus operand byte, and sets carry to bit 8 of that sum.
- R5: Store (10aaaaaa) raises the write strobe for exactly one cycle, in DATA_XFER, with the accumulator on write data. Address and write data are unchanged from the previous cycle. No other instruction writes.
- R6: A branch (11aaaaaa, aaaaaa below 60) loads aaaaaa into PC only when carry is 0. It clears carry whether or not it is taken.
- R7: Control bytes 0xFC to 0xFF never change PC other than the normal step, and they clear carry like a branch.
- R8: Operand addresses are {data slice, aaaaaa} in data mode and {0x00, aaaaaa} in scratch mode. 0xFD enters scratch mode and 0xFC leaves it.
- R9: 0xFE copies the accumulator into the data slice. 0xFF copies it into the code slice, which takes effect at the very next fetch while PC keeps stepping.
- R10: NOR, ADD and store take four cycles each. Branches and control bytes take two cycles each.
- R11: Reset clears the accumulator, carry and PC, sets both slice registers to 0x80, and selects data mode.
- R12: The read strobe is high in CODE_ADDR and CODE_READ, and in both data states of NOR and ADD. It is low in both data states of a store. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 14 | Memory address, {slice, offset} |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rdata | input | 8 | Read data from the asynchronous memory |

## Verification
One program drives the core through every instruction kind. It includes an ADD that wraps and sets carry, followed by a branch that falls through and a second branch that is taken, which separates "taken only when carry is clear" from "always taken" or "never taken". It also runs a store in scratch mode and a load in scratch mode, which separate the fixed scratch slice from the data-slice register, and then a change of data slice and a change of code slice in the middle of the program, which show when each new slice takes effect. Each store is compared with the expected address, data and cycle number, so an extra phase, a missing phase or a skipped instruction shows up as a timing or ordering mismatch. Areas in memory that a correct core must never write are inspected at the end.

// File: rtl/slice_acc_pkg.sv
package slice_acc_pkg;

    // Sequencer states of one instruction
    typedef enum logic [1:0] {
        PH_CODE_ADDR = 2'd0,
        PH_CODE_READ = 2'd1,
        PH_DATA_ADDR = 2'd2,
        PH_DATA_XFER = 2'd3
    } phase_e;

    // Major opcode in the top two bits of an instruction byte
    typedef enum logic [1:0] {
        OP_NOR    = 2'b00,
        OP_ADD    = 2'b01,
        OP_STORE  = 2'b10,
        OP_BRANCH = 2'b11
    } opcode_e;

    // Low two operand bits of a control byte (operand 60..63)
    typedef enum logic [1:0] {
        CTL_USE_DATA    = 2'b00,
        CTL_USE_SCRATCH = 2'b01,
        CTL_SET_DSLICE  = 2'b10,
        CTL_SET_CSLICE  = 2'b11
    } ctl_e;

endpackage

// File: rtl/slice_acc_seq.sv
module slice_acc_seq
    import slice_acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e fetched_op,
    input  opcode_e held_op,
    output phase_e  phase,
    output logic    fetch_done,
    output logic    data_done,
    output logic    data_sel,
    output logic    mem_rd,
    output logic    mem_wr
);

    phase_e phase_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_CODE_ADDR;
        end else begin
            phase <= phase_nx;
        end
    end

    // Transitions
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_CODE_ADDR: phase_nx = PH_CODE_READ;
            PH_CODE_READ: phase_nx = (fetched_op == OP_BRANCH) ? PH_CODE_ADDR
                                                               : PH_DATA_ADDR;
            PH_DATA_ADDR: phase_nx = PH_DATA_XFER;
            PH_DATA_XFER: phase_nx = PH_CODE_ADDR;
        endcase
    end

    // Outputs per state
    always_comb begin
        fetch_done = 1'b0;
        data_done  = 1'b0;
        data_sel   = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        unique case (phase)
            PH_CODE_ADDR: begin
                mem_rd = 1'b1;
            end
            PH_CODE_READ: begin
                mem_rd     = 1'b1;
                fetch_done = 1'b1;
            end
            PH_DATA_ADDR: begin
                data_sel = 1'b1;
                mem_rd   = (held_op != OP_STORE);
            end
            PH_DATA_XFER: begin
                data_sel = 1'b1;
                if (held_op == OP_STORE) begin
                    mem_wr = 1'b1;
                end else begin
                    mem_rd    = 1'b1;
                    data_done = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/slice_acc_alu.sv
module slice_acc_alu
    import slice_acc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    logic [DATA_W:0] sum;

    always_comb begin
        sum       = {1'b0, acc} + {1'b0, opnd};
        carry_out = sum[DATA_W];
        unique case (op)
            OP_NOR:  result = ~(acc | opnd);
            OP_ADD:  result = sum[DATA_W-1:0];
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/slice_acc_addr.sv
module slice_acc_addr #(
    parameter int                  SLICE_W       = 8,
    parameter int                  OFS_W         = 6,
    parameter logic [SLICE_W-1:0]  SCRATCH_SLICE = '0,
    localparam int                 ADDR_W        = SLICE_W + OFS_W
) (
    input  logic               data_sel,
    input  logic               scratch,
    input  logic [SLICE_W-1:0] code_slice,
    input  logic [OFS_W-1:0]   pc,
    input  logic [SLICE_W-1:0] data_slice,
    input  logic [OFS_W-1:0]   opnd_ofs,
    output logic [ADDR_W-1:0]  addr
);

    logic [SLICE_W-1:0] opnd_slice;

    always_comb begin
        opnd_slice = scratch ? SCRATCH_SLICE : data_slice;
        addr       = data_sel ? {opnd_slice, opnd_ofs} : {code_slice, pc};
    end

endmodule

// File: rtl/slice_acc_regs.sv
module slice_acc_regs
    import slice_acc_pkg::*;
#(
    parameter int                 DATA_W     = 8,
    parameter int                 SLICE_W    = 8,
    parameter logic [SLICE_W-1:0] BOOT_SLICE = 8'h80,
    localparam int                OFS_W      = DATA_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_done,
    input  logic               data_done,
    input  logic [DATA_W-1:0]  code_byte,
    input  logic [DATA_W-1:0]  alu_result,
    input  logic               alu_carry,
    output opcode_e            ir_op,
    output logic [OFS_W-1:0]   ir_ofs,
    output logic [DATA_W-1:0]  acc,
    output logic               carry,
    output logic [OFS_W-1:0]   pc,
    output logic [SLICE_W-1:0] code_slice,
    output logic [SLICE_W-1:0] data_slice,
    output logic               scratch
);

    localparam logic [OFS_W-1:0] PC_ONE = 1;

    logic [DATA_W-1:0] ir;
    opcode_e           code_op;
    logic [OFS_W-1:0]  code_ofs;
    logic              code_is_ctl;
    ctl_e              code_ctl;
    logic [OFS_W-1:0]  pc_step;

    always_comb begin
        code_op     = opcode_e'(code_byte[DATA_W-1 -: 2]);
        code_ofs    = code_byte[OFS_W-1:0];
        code_is_ctl = &code_ofs[OFS_W-1:2];
        code_ctl    = ctl_e'(code_ofs[1:0]);
        pc_step     = pc + PC_ONE;
        ir_op       = opcode_e'(ir[DATA_W-1 -: 2]);
        ir_ofs      = ir[OFS_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir         <= '0;
            acc        <= '0;
            carry      <= 1'b0;
            pc         <= '0;
            code_slice <= BOOT_SLICE;
            data_slice <= BOOT_SLICE;
            scratch    <= 1'b0;
        end else begin
            if (fetch_done) begin
                ir <= code_byte;
                pc <= pc_step;
                if (code_op == OP_BRANCH) begin
                    carry <= 1'b0;
                    if (code_is_ctl) begin
                        unique case (code_ctl)
                            CTL_USE_DATA:    scratch    <= 1'b0;
                            CTL_USE_SCRATCH: scratch    <= 1'b1;
                            CTL_SET_DSLICE:  data_slice <= acc;
                            CTL_SET_CSLICE:  code_slice <= acc;
                        endcase
                    end else if (!carry) begin
                        pc <= code_ofs;
                    end
                end
            end
            if (data_done) begin
                acc <= alu_result;
                if (ir_op == OP_ADD) begin
                    carry <= alu_carry;
                end
            end
        end
    end

endmodule

// File: rtl/slice_acc_cpu.sv
module slice_acc_cpu
    import slice_acc_pkg::*;
#(
    parameter int                 DATA_W        = 8,
    parameter int                 SLICE_W       = 8,
    parameter logic [SLICE_W-1:0] BOOT_SLICE    = 8'h80,
    parameter logic [SLICE_W-1:0] SCRATCH_SLICE = '0,
    localparam int                OFS_W         = DATA_W - 2,
    localparam int                ADDR_W        = SLICE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    phase_e             phase;
    logic               fetch_done;
    logic               data_done;
    logic               data_sel;
    opcode_e            ir_op;
    opcode_e            fetched_op;
    logic [OFS_W-1:0]   ir_ofs;
    logic [DATA_W-1:0]  acc;
    logic               carry;
    logic [OFS_W-1:0]   pc;
    logic [SLICE_W-1:0] code_slice;
    logic [SLICE_W-1:0] data_slice;
    logic               scratch;
    logic [DATA_W-1:0]  alu_result;
    logic               alu_carry;

    assign fetched_op = opcode_e'(mem_rdata[DATA_W-1 -: 2]);
    assign mem_wdata  = acc;

    slice_acc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetched_op (fetched_op),
        .held_op    (ir_op),
        .phase      (phase),
        .fetch_done (fetch_done),
        .data_done  (data_done),
        .data_sel   (data_sel),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr)
    );

    slice_acc_regs #(
        .DATA_W     (DATA_W),
        .SLICE_W    (SLICE_W),
        .BOOT_SLICE (BOOT_SLICE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_done (fetch_done),
        .data_done  (data_done),
        .code_byte  (mem_rdata),
        .alu_result (alu_result),
        .alu_carry  (alu_carry),
        .ir_op      (ir_op),
        .ir_ofs     (ir_ofs),
        .acc        (acc),
        .carry      (carry),
        .pc         (pc),
        .code_slice (code_slice),
        .data_slice (data_slice),
        .scratch    (scratch)
    );

    slice_acc_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op        (ir_op),
        .acc       (acc),
        .opnd      (mem_rdata),
        .result    (alu_result),
        .carry_out (alu_carry)
    );

    slice_acc_addr #(
        .SLICE_W       (SLICE_W),
        .OFS_W         (OFS_W),
        .SCRATCH_SLICE (SCRATCH_SLICE)
    ) u_addr (
        .data_sel   (data_sel),
        .scratch    (scratch),
        .code_slice (code_slice),
        .pc         (pc),
        .data_slice (data_slice),
        .opnd_ofs   (ir_ofs),
        .addr       (mem_addr)
    );

endmodule

// File: rtl/slice_acc_cpu_chk.sv
module slice_acc_cpu_chk
    import slice_acc_pkg::*;
#(
    parameter int  DATA_W  = 8,
    parameter int  SLICE_W = 8,
    localparam int OFS_W   = DATA_W - 2,
    localparam int ADDR_W  = SLICE_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [1:0]        phase,
    input logic [OFS_W-1:0]  pc,
    input logic              carry
);

    logic fetching_branch;
    assign fetching_branch = (phase == PH_CODE_READ) && (mem_rdata[DATA_W-1 -: 2] == 2'b11);

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    p_wr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($stable(mem_addr) && $stable(mem_wdata)));

    p_code_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CODE_ADDR) |=> (phase == PH_CODE_READ));

    p_data_seq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA_ADDR) |=> (phase == PH_DATA_XFER));

    p_short_instr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetching_branch |=> (phase == PH_CODE_ADDR));

    p_branch_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetching_branch |=> !carry);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_CODE_READ) && !fetching_branch) |=> (pc == OFS_W'($past(pc) + 1'b1)));

endmodule

bind slice_acc_cpu slice_acc_cpu_chk #(
    .DATA_W  (DATA_W),
    .SLICE_W (SLICE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .phase     (phase),
    .pc        (pc),
    .carry     (carry)
);

// File: tb/slice_acc_cpu_test.sv
`timescale 1ns/1ps
module slice_acc_cpu_test;

    localparam int MEM_WORDS = 16384;
    localparam int WATCHDOG  = 2000;

    typedef struct {
        logic [13:0] addr;
        logic [7:0]  data;
        int          cyc;
        string       req;
    } wr_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [0:MEM_WORDS-1];
    wr_item_t    exp_q [$];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_writes = 0;
    bit          done = 1'b0;
    bit          prev_wr = 1'b0;

    always #4 clk = ~clk;

    slice_acc_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Asynchronous memory model
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] = mem_wdata;
    end

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        else       cyc <= 0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push_wr(input logic [13:0] a, input logic [7:0] d, input int c, input string req);
        wr_item_t it;
        it.addr = a; it.data = d; it.cyc = c; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: pops one expected store per observed write strobe
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_wr && prev_wr) chk("R5 strobe width", 32'd2, 32'd1);
            if (mem_wr) begin
                n_writes++;
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected write addr", {18'd0, mem_addr}, 32'hFFFF);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    chk({it.req, " store addr"}, {18'd0, mem_addr}, {18'd0, it.addr});
                    chk({it.req, " store data"}, {24'd0, mem_wdata}, {24'd0, it.data});
                    chk({it.req, " R10 store cycle"}, cyc, it.cyc);
                    chk({it.req, " R12 rd low in store"}, {31'd0, mem_rd}, 32'd0);
                end
            end
            prev_wr = mem_wr;
        end
    end

    task automatic load_program();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 8'h00;
        // code slice 0x80
        mem[14'h2000] = 8'h32; // NOR 50
        mem[14'h2001] = 8'hA8; // store 40
        mem[14'h2002] = 8'h71; // ADD 49  (wrap, carry 1)
        mem[14'h2003] = 8'hA9; // store 41
        mem[14'h2004] = 8'hCA; // branch 10 (not taken)
        mem[14'h2005] = 8'h76; // ADD 54
        mem[14'h2006] = 8'h77; // ADD 55  (carry 1)
        mem[14'h2007] = 8'hAA; // store 42
        mem[14'h2008] = 8'hCC; // branch 12 (not taken)
        mem[14'h2009] = 8'hCC; // branch 12 (taken)
        mem[14'h200A] = 8'hAB; // skipped
        mem[14'h200B] = 8'hAB; // skipped
        mem[14'h200C] = 8'h32; // NOR 50
        mem[14'h200D] = 8'hAC; // store 44
        mem[14'h200E] = 8'hFD; // scratch mode
        mem[14'h200F] = 8'h85; // store 5 (scratch)
        mem[14'h2010] = 8'h30; // NOR 48 (scratch)
        mem[14'h2011] = 8'hFC; // data mode
        mem[14'h2012] = 8'hAD; // store 45
        mem[14'h2013] = 8'h30; // NOR 48
        mem[14'h2014] = 8'h73; // ADD 51
        mem[14'h2015] = 8'hFE; // data slice <- 0x41
        mem[14'h2016] = 8'h87; // store 7
        mem[14'h2017] = 8'h70; // ADD 48 (carry 1)
        mem[14'h2018] = 8'hFC; // control byte clears carry
        mem[14'h2019] = 8'hDB; // branch 27 (taken)
        mem[14'h201A] = 8'h88; // skipped
        mem[14'h201B] = 8'h30; // NOR 48
        mem[14'h201C] = 8'h74; // ADD 52
        mem[14'h201D] = 8'hFF; // code slice <- 0x81
        mem[14'h2030] = 8'hFF;
        mem[14'h2031] = 8'h01;
        mem[14'h2033] = 8'h41;
        mem[14'h2036] = 8'hC8;
        mem[14'h2037] = 8'h64;
        // code slice 0x81, offsets 30..33
        mem[14'h205E] = 8'h89; // store 9
        mem[14'h205F] = 8'h75; // ADD 53
        mem[14'h2060] = 8'h8A; // store 10
        mem[14'h2061] = 8'hE1; // branch to self
        // data slice 0x41 constants
        mem[14'h1070] = 8'hFF;
        mem[14'h1074] = 8'h81;
        mem[14'h1075] = 8'h05;
        // scratch slice constant
        mem[14'h0030] = 8'h0F;
    endtask

    // Driver
    initial begin
        load_program();
        push_wr(14'h2028, 8'hFF,   7, "R11");
        push_wr(14'h2029, 8'h00,  15, "R4");
        push_wr(14'h202A, 8'h2C,  29, "R4");
        push_wr(14'h202C, 8'hD3,  41, "R3");
        push_wr(14'h0005, 8'hD3,  47, "R8");
        push_wr(14'h202D, 8'h20,  57, "R8");
        push_wr(14'h1047, 8'h41,  71, "R9");
        push_wr(14'h1049, 8'h81,  93, "R9");
        push_wr(14'h104A, 8'h86, 101, "R10");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 first address", {18'd0, mem_addr}, 32'h2000);
        chk("R1 read strobe", {31'd0, mem_rd}, 32'd1);
        chk("R1 write strobe", {31'd0, mem_wr}, 32'd0);
        wait_cyc(6);
        chk("R8 data-mode operand address", {18'd0, mem_addr}, 32'h2028);
        chk("R12 rd low in store address state", {31'd0, mem_rd}, 32'd0);
        wait_cyc(50);
        chk("R8 scratch operand address", {18'd0, mem_addr}, 32'h0030);
        chk("R12 rd high in load address state", {31'd0, mem_rd}, 32'd1);
        wait_cyc(90);
        chk("R9 fetch after code slice change", {18'd0, mem_addr}, 32'h205E);
        wait_cyc(140);
        chk("R2 self branch holds fetch address", {18'd0, mem_addr}, 32'h2061);
        done = 1'b1;
        chk("R5 store count", n_writes, 32'd9);
        chk("R5 scoreboard drained", exp_q.size(), 32'd0);
        chk("R11 mem 0x2028", {24'd0, mem[14'h2028]}, 32'hFF);
        chk("R4 mem 0x202A", {24'd0, mem[14'h202A]}, 32'h2C);
        chk("R3 mem 0x202C", {24'd0, mem[14'h202C]}, 32'hD3);
        chk("R8 mem 0x0005", {24'd0, mem[14'h0005]}, 32'hD3);
        chk("R9 mem 0x1047", {24'd0, mem[14'h1047]}, 32'h41);
        chk("R10 mem 0x104A", {24'd0, mem[14'h104A]}, 32'h86);
        chk("R6 skipped store 0x202B", {24'd0, mem[14'h202B]}, 32'h00);
        chk("R7 skipped store 0x1048", {24'd0, mem[14'h1048]}, 32'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog: got timeout expected program end");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule